// File: doc/BRIEF.md
# Crash Diagnostic Memory Readout Port

After a node has gone into its fault state, this block lets a bus master read local memory back one byte at a time. It sits behind a bus slave engine that has already decoded the traffic into byte writes and byte-read requests. It also sees a one-cycle strobe that marks entry into the fault state.

Before the fault strobe, the block is inert. After the strobe, the master must first write an all-zero byte. That byte unlocks readout and clears the address pointer. The master then builds a 12-bit address by shifting in tagged 6-bit chunks. Each byte it reads returns the memory byte at the pointer, and the pointer then advances by one.

Reads made before the unlock return fixed placeholder bytes. The local RAM is synchronous, and the block keeps the byte at the current pointer prefetched on the RAM output. A read request must come at least one idle cycle after the pointer last changed.

Top module: `crash_readout`

## Requirements
- R1: After reset, `readout_active` is 0, `mem_rd_en` is 0 and `rd_data` is 0x00.
- R2: A `fault_enter` pulse sets `readout_active` from the next cycle until reset. It also clears the unlock flag and sets the pointer to 0, including when readout is already active.
- R3: While readout is active but not unlocked, a read with `rd_first`=1 returns 0x80 and a read with `rd_first`=0 returns 0x0B.
- R4: While not unlocked, every non-zero written byte is ignored, so later reads still return the placeholder bytes.
- R5: A written 0x00 during readout unlocks it and sets the pointer to 0, so the next read returns memory byte 0.
- R6: Once unlocked, a written byte 01bbbbbb sets pointer = (pointer << 6) | bbbbbb on 12 bits. Bits shifted out at the top are lost.
- R7: Once unlocked, each read returns the RAM byte at the pointer and then increments the pointer. The pointer wraps from 0xFFF to 0x000.
- R8: Once unlocked, written bytes with bit 7 set, or in the range 0x01 to 0x3F, leave the pointer unchanged.
- R9: While readout is not active, writes have no effect and `rd_data` stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_enter | input | 1 | One-cycle strobe on entry to the fault state |
| wr_valid | input | 1 | A byte written by the master is present |
| wr_data | input | 8 | Written command byte |
| rd_req | input | 1 | Master takes a byte this cycle |
| rd_first | input | 1 | The read is the first byte of its transaction |
| mem_rdata | input | 8 | RAM read data, one cycle after `mem_addr` |
| rd_data | output | 8 | Byte handed to the bus engine during `rd_req` |
| readout_active | output | 1 | Fault readout mode is active |
| mem_addr | output | 12 | RAM address, equal to the readout pointer |
| mem_rd_en | output | 1 | RAM read enable, high once unlocked |

## Verification
Writes and the fault strobe take effect at the clock edge that samples them, and the pointer drives the RAM address directly. A memory byte therefore appears on `rd_data` one edge after the pointer settles. The driver always leaves an idle cycle after each write and after each read, and it issues the next read only after that gap. Placeholder bytes and idle outputs are combinational, so the monitor samples `rd_data` shortly after the falling edge of the cycle in which `rd_req` is high. It compares that sample with the value the driver queued from its own pointer and unlock model.

// File: rtl/crash_readout.sv
module crash_readout #(
  parameter int PTR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_enter,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  input  logic             rd_req,
  input  logic             rd_first,
  input  logic [7:0]       mem_rdata,
  output logic [7:0]       rd_data,
  output logic             readout_active,
  output logic [PTR_W-1:0] mem_addr,
  output logic             mem_rd_en
);
  localparam int CHUNK = 6;
  localparam logic [7:0] FIRST_FILL = 8'h80;
  localparam logic [7:0] NEXT_FILL  = 8'h0B;

  logic             active_q, unlocked_q;
  logic [PTR_W-1:0] ptr_q;

  wire is_zero  = (wr_data == 8'h00);
  wire is_shift = (wr_data[7:6] == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      unlocked_q <= 1'b0;
      ptr_q      <= '0;
    end else if (fault_enter) begin
      active_q   <= 1'b1;
      unlocked_q <= 1'b0;
      ptr_q      <= '0;
    end else if (active_q) begin
      if (wr_valid) begin
        if (is_zero) begin
          unlocked_q <= 1'b1;
          ptr_q      <= '0;
        end else if (unlocked_q && is_shift) begin
          ptr_q <= {ptr_q[PTR_W-CHUNK-1:0], wr_data[CHUNK-1:0]};
        end
      end else if (rd_req && unlocked_q) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign readout_active = active_q;
  assign mem_addr       = ptr_q;
  assign mem_rd_en      = active_q & unlocked_q;
  assign rd_data        = !active_q  ? 8'h00 :
                          unlocked_q ? mem_rdata :
                          rd_first   ? FIRST_FILL : NEXT_FILL;
endmodule

module crash_readout_chk #(
  parameter int PTR_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fault_enter,
  input logic             wr_valid,
  input logic [7:0]       wr_data,
  input logic             rd_req,
  input logic             rd_first,
  input logic [7:0]       rd_data,
  input logic             readout_active,
  input logic [PTR_W-1:0] mem_addr,
  input logic             mem_rd_en
);
  a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !readout_active |-> (rd_data == 8'h00) && !mem_rd_en);

  a_r2_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    readout_active |=> readout_active);

  a_r2_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fault_enter |=> readout_active && !mem_rd_en && (mem_addr == '0));

  a_r3_first_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_active && !mem_rd_en && rd_req && rd_first) |-> rd_data == 8'h80);

  a_r4_locked_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_active && !mem_rd_en && wr_valid && wr_data != 8'h00 && !fault_enter)
      |=> !mem_rd_en && $stable(mem_addr));

  a_r6_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_active && mem_rd_en && wr_valid && wr_data[7:6] == 2'b01 && !fault_enter)
      |=> mem_addr == {$past(mem_addr[PTR_W-7:0]), $past(wr_data[5:0])});

  a_r7_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_active && mem_rd_en && rd_req && !wr_valid && !fault_enter)
      |=> mem_addr == $past(mem_addr) + 1'b1);

  a_r8_unlocked_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (readout_active && mem_rd_en && wr_valid && !fault_enter &&
     (wr_data[7] || (wr_data[7:6] == 2'b00 && wr_data != 8'h00)))
      |=> $stable(mem_addr) && mem_rd_en);
endmodule

bind crash_readout crash_readout_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_enter(fault_enter), .wr_valid(wr_valid),
  .wr_data(wr_data), .rd_req(rd_req), .rd_first(rd_first), .rd_data(rd_data),
  .readout_active(readout_active), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en)
);

// File: tb/test_crash_readout.sv
`timescale 1ns/1ps
module test_crash_readout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_enter = 1'b0, wr_valid = 1'b0, rd_req = 1'b0, rd_first = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  rd_data;
  logic        readout_active, mem_rd_en;
  logic [11:0] mem_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic        m_active = 1'b0, m_unlocked = 1'b0;
  logic [11:0] m_ptr = '0;

  always #2 clk = ~clk;

  crash_readout i_crash_readout (
    .clk(clk), .rst_n(rst_n), .fault_enter(fault_enter), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_first(rd_first), .mem_rdata(mem_rdata),
    .rd_data(rd_data), .readout_active(readout_active), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en)
  );

  function automatic logic [7:0] memf(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= memf(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rd_req) begin
      if (exp_q.size() == 0) chk(1'b0, "scoreboard", rd_data, 8'hxx);
      else chk(rd_data === exp_q[0], tag_q[0], rd_data, exp_q[0]);
      if (exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0;
    @(negedge clk);
    if (m_active) begin
      if (b == 8'h00) begin m_unlocked = 1'b1; m_ptr = '0; end
      else if (m_unlocked && b[7:6] == 2'b01) m_ptr = {m_ptr[5:0], b[5:0]};
    end
  endtask

  task automatic rd(input bit first, input string req);
    logic [7:0] e;
    if (!m_active) e = 8'h00;
    else if (m_unlocked) e = memf(m_ptr);
    else e = first ? 8'h80 : 8'h0B;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk); rd_req = 1'b1; rd_first = first;
    @(negedge clk); rd_req = 1'b0; rd_first = 1'b0;
    @(negedge clk);
    if (m_active && m_unlocked) m_ptr = m_ptr + 1'b1;
  endtask

  task automatic fault();
    @(negedge clk); fault_enter = 1'b1;
    @(negedge clk); fault_enter = 1'b0;
    @(negedge clk);
    m_active = 1'b1; m_unlocked = 1'b0; m_ptr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(readout_active == 1'b0, "R1 active", {7'd0, readout_active}, 8'h00);
    chk(mem_rd_en == 1'b0, "R1 rd_en", {7'd0, mem_rd_en}, 8'h00);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 8'h00);

    wr(8'h00); wr(8'h41);
    rd(1'b1, "R9 pre-fault read");
    chk(readout_active == 1'b0, "R9 active", {7'd0, readout_active}, 8'h00);

    fault();
    chk(readout_active == 1'b1, "R2 active", {7'd0, readout_active}, 8'h01);
    chk(mem_addr == 12'h000, "R2 pointer", mem_addr[7:0], 8'h00);
    rd(1'b1, "R3 first fill");
    rd(1'b0, "R3 next fill");
    rd(1'b0, "R3 next fill");

    wr(8'h45); wr(8'h80);
    rd(1'b1, "R4 locked ignore");
    chk(mem_rd_en == 1'b0, "R4 still locked", {7'd0, mem_rd_en}, 8'h00);

    wr(8'h00);
    rd(1'b1, "R5 unlock byte 0");
    rd(1'b0, "R7 post increment");

    wr(8'h41); wr(8'h7F);
    rd(1'b1, "R6 two chunks");
    rd(1'b0, "R7 next");
    wr(8'h4A);
    rd(1'b1, "R6 top discarded");

    wr(8'h85); wr(8'h25); wr(8'h15); wr(8'h05); wr(8'hFF);
    rd(1'b1, "R8 ignored bytes");

    wr(8'h7F); wr(8'h7F);
    rd(1'b1, "R7 top address");
    rd(1'b0, "R7 wrap");

    wr(8'h43);
    fault();
    chk(readout_active == 1'b1, "R2 sticky", {7'd0, readout_active}, 8'h01);
    rd(1'b1, "R2 relocked");
    wr(8'h00);
    rd(1'b1, "R2 pointer cleared");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size() > 255 ? 8'hFF : 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule